// File: doc/BRIEF.md
# Forwarded-Clock Flit Channel Bridge

This block moves flits of one channel, in one direction, between two clock domains that share no frequency or phase relation. The sending half lives beside the sender. It accepts flits with a valid/ready handshake, keeps the write pointer and the full flag, and sends its own clock across the boundary along with each flit, the write strobe and the slot index. The receiving half holds the storage. It writes that storage on the forwarded clock, not on its own. Its read pointer and empty flag run in the receiver's clock, and it presents the oldest flit with a valid/ready handshake.

Pointers cross between the halves in Gray code through two-flop synchronizers. Each half has its own active-low reset, which is released through a local synchronizer. A link to a memory-side agent places one instance on each of its request, response and data channels. A link to a compute-cluster agent does the same for request, response, data and snoop. Each instance carries its own forwarded clock. A boundary that uses this bridge carries no plain register slice.

Top module: `ssb_channel`

## Requirements
- R1: Once both resets have been released and two cycles of each clock have passed, `dst_vld` is 0 and `src_rdy` is 1.
- R2: Every flit accepted at the source (`src_vld` and `src_rdy` both 1 on a `src_clk` rising edge) comes out at the destination exactly once and in acceptance order. This holds for any ratio of the two clocks and any pattern of handshakes.
- R3: With `DEPTH` flits accepted and none removed, `src_rdy` is 0. The bridge never holds more than `DEPTH` flits.
- R4: While `dst_vld` is 1 and `dst_rdy` is 0, both `dst_vld` and `dst_flit` stay unchanged on the next `dst_clk` edge.
- R5: A flit offered while `src_rdy` is 0 is not taken. It never appears at the destination and does not change any stored flit.
- R6: A flit written into an empty bridge raises `dst_vld` no sooner than the second `dst_clk` rising edge after the write, and no later than the fourth.
- R7: After one flit leaves a full bridge, `src_rdy` returns to 1 within 8 `src_clk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Sender clock, which is also forwarded to write the storage |
| src_rst_n | input | 1 | Sender-half reset, active low, asynchronous assert |
| src_vld | input | 1 | Sender offers a flit |
| src_rdy | output | 1 | Bridge can take a flit (not full) |
| src_flit | input | FLIT_W | Flit payload from the sender |
| dst_clk | input | 1 | Receiver clock |
| dst_rst_n | input | 1 | Receiver-half reset, active low, asynchronous assert |
| dst_vld | output | 1 | Oldest stored flit is presented |
| dst_rdy | input | 1 | Receiver takes the presented flit |
| dst_flit | output | FLIT_W | Oldest stored flit |

## Verification
The assertions check on every cycle that each half's view of the occupancy never exceeds `DEPTH`, that `src_rdy` is 0 whenever the sender-side occupancy reaches `DEPTH`, and that a stalled output holds its flit. Ordering without loss or duplication across several clock ratios, the synchronizer latency window of R6 and the release of back-pressure after a pop involve both clocks together. Only the directed scenarios can show those, by keeping a reference queue and timing the edges.

// File: rtl/ssb_pkg.sv
package ssb_pkg;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/ssb_sync.sv
module ssb_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/ssb_tx_half.sv
module ssb_tx_half #(
  parameter int FLIT_W = 32,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic              src_vld,
  output logic              src_rdy,
  input  logic [FLIT_W-1:0] src_flit,
  input  logic [PW-1:0]     rd_gray_async,
  output logic              fwd_clk,
  output logic              fwd_wen,
  output logic [AW-1:0]     fwd_waddr,
  output logic [FLIT_W-1:0] fwd_flit,
  output logic [PW-1:0]     wr_gray
);
  logic          rst_n_s;
  logic [PW-1:0] rd_gray_s;
  logic [PW-1:0] wbin_q, wbin_nxt;
  logic [PW-1:0] wgray_q, wgray_nxt;
  logic          full;
  logic          push;

  ssb_sync #(.W(1)) u_rst_sync (
    .clk(src_clk), .rst_n(src_rst_n), .d(1'b1), .q(rst_n_s)
  );

  ssb_sync #(.W(PW)) u_rd_sync (
    .clk(src_clk), .rst_n(rst_n_s), .d(rd_gray_async), .q(rd_gray_s)
  );

  always_comb begin
    full      = (wgray_q == {~rd_gray_s[PW-1:PW-2], rd_gray_s[PW-3:0]});
    push      = src_vld & ~full;
    wbin_nxt  = wbin_q + PW'(1);
    wgray_nxt = PW'(ssb_pkg::bin2gray(32'(wbin_nxt)));
  end

  always_ff @(posedge src_clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (push) begin
      wbin_q  <= wbin_nxt;
      wgray_q <= wgray_nxt;
    end
  end

  assign src_rdy   = ~full;
  assign fwd_clk   = src_clk;
  assign fwd_wen   = push;
  assign fwd_waddr = wbin_q[AW-1:0];
  assign fwd_flit  = src_flit;
  assign wr_gray   = wgray_q;

  logic [PW-1:0] occ_w;
  assign occ_w = wbin_q - PW'(ssb_pkg::gray2bin(32'(rd_gray_s)));

  AST_NO_OVERFLOW: assert property (@(posedge src_clk) disable iff (!rst_n_s)
    occ_w <= PW'(DEPTH)); // R3
  AST_FULL_AT_DEPTH: assert property (@(posedge src_clk) disable iff (!rst_n_s)
    (occ_w == PW'(DEPTH)) |-> !src_rdy); // R3
endmodule

// File: rtl/ssb_rx_half.sv
module ssb_rx_half #(
  parameter int FLIT_W = 32,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic              fwd_clk,
  input  logic              fwd_wen,
  input  logic [AW-1:0]     fwd_waddr,
  input  logic [FLIT_W-1:0] fwd_flit,
  input  logic [PW-1:0]     wr_gray_async,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic              dst_vld,
  input  logic              dst_rdy,
  output logic [FLIT_W-1:0] dst_flit,
  output logic [PW-1:0]     rd_gray
);
  logic [FLIT_W-1:0] store_q [DEPTH];
  logic              rst_n_s;
  logic [PW-1:0]     wr_gray_s;
  logic [PW-1:0]     rbin_q, rbin_nxt;
  logic [PW-1:0]     rgray_q, rgray_nxt;
  logic              empty;
  logic              pop;

  // storage written in the forwarded (sender) clock domain
  always_ff @(posedge fwd_clk) begin
    if (fwd_wen) store_q[fwd_waddr] <= fwd_flit;
  end

  ssb_sync #(.W(1)) u_rst_sync (
    .clk(dst_clk), .rst_n(dst_rst_n), .d(1'b1), .q(rst_n_s)
  );

  ssb_sync #(.W(PW)) u_wr_sync (
    .clk(dst_clk), .rst_n(rst_n_s), .d(wr_gray_async), .q(wr_gray_s)
  );

  always_comb begin
    empty     = (rgray_q == wr_gray_s);
    pop       = ~empty & dst_rdy;
    rbin_nxt  = rbin_q + PW'(1);
    rgray_nxt = PW'(ssb_pkg::bin2gray(32'(rbin_nxt)));
  end

  always_ff @(posedge dst_clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (pop) begin
      rbin_q  <= rbin_nxt;
      rgray_q <= rgray_nxt;
    end
  end

  assign dst_vld  = ~empty;
  assign dst_flit = store_q[rbin_q[AW-1:0]];
  assign rd_gray  = rgray_q;

  logic [PW-1:0] occ_r;
  assign occ_r = PW'(ssb_pkg::gray2bin(32'(wr_gray_s))) - rbin_q;

  AST_NO_UNDERFLOW: assert property (@(posedge dst_clk) disable iff (!rst_n_s)
    occ_r <= PW'(DEPTH)); // R2
  AST_EMPTY_NO_VALID: assert property (@(posedge dst_clk) disable iff (!rst_n_s)
    (occ_r == '0) |-> !dst_vld); // R2
  AST_HEAD_STABLE: assert property (@(posedge dst_clk) disable iff (!rst_n_s)
    (dst_vld && !dst_rdy) |=> (dst_vld && $stable(dst_flit))); // R4
endmodule

// File: rtl/ssb_channel.sv
module ssb_channel #(
  parameter int FLIT_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic              src_vld,
  output logic              src_rdy,
  input  logic [FLIT_W-1:0] src_flit,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic              dst_vld,
  input  logic              dst_rdy,
  output logic [FLIT_W-1:0] dst_flit
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  if (DEPTH < 4 || (1 << AW) != DEPTH) begin : g_bad_depth
    $error("DEPTH must be a power of two and at least 4");
  end

  logic              fwd_clk;
  logic              fwd_wen;
  logic [AW-1:0]     fwd_waddr;
  logic [FLIT_W-1:0] fwd_flit;
  logic [PW-1:0]     wr_gray;
  logic [PW-1:0]     rd_gray;

  ssb_tx_half #(.FLIT_W(FLIT_W), .DEPTH(DEPTH)) u_tx (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_vld(src_vld),
    .src_rdy(src_rdy), .src_flit(src_flit), .rd_gray_async(rd_gray),
    .fwd_clk(fwd_clk), .fwd_wen(fwd_wen), .fwd_waddr(fwd_waddr),
    .fwd_flit(fwd_flit), .wr_gray(wr_gray)
  );

  ssb_rx_half #(.FLIT_W(FLIT_W), .DEPTH(DEPTH)) u_rx (
    .fwd_clk(fwd_clk), .fwd_wen(fwd_wen), .fwd_waddr(fwd_waddr),
    .fwd_flit(fwd_flit), .wr_gray_async(wr_gray), .dst_clk(dst_clk),
    .dst_rst_n(dst_rst_n), .dst_vld(dst_vld), .dst_rdy(dst_rdy),
    .dst_flit(dst_flit), .rd_gray(rd_gray)
  );
endmodule

// File: tb/ssb_channel_tb.sv
`timescale 1ns/1ps
module ssb_channel_tb;
  localparam int W = 32;
  localparam int D = 8;

  logic         src_clk, src_rst_n, src_vld, src_rdy;
  logic [W-1:0] src_flit;
  logic         dst_clk, dst_rst_n, dst_vld, dst_rdy;
  logic [W-1:0] dst_flit;
  real          dst_half = 5.3;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [W-1:0] exp_q[$];

  ssb_channel #(.FLIT_W(W), .DEPTH(D)) u_dut (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_vld(src_vld),
    .src_rdy(src_rdy), .src_flit(src_flit), .dst_clk(dst_clk),
    .dst_rst_n(dst_rst_n), .dst_vld(dst_vld), .dst_rdy(dst_rdy),
    .dst_flit(dst_flit)
  );

  initial begin src_clk = 0; forever #4 src_clk = ~src_clk; end
  initial begin dst_clk = 0; forever #(dst_half) dst_clk = ~dst_clk; end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic t_reset();
    src_rst_n = 0; dst_rst_n = 0; src_vld = 0; src_flit = '0; dst_rdy = 0;
    repeat (3) @(negedge src_clk);
    src_rst_n = 1;
    @(negedge dst_clk) dst_rst_n = 1;
    repeat (4) @(negedge src_clk);
    repeat (4) @(negedge dst_clk);
    chk(dst_vld == 1'b0, "R1", "dst_vld after reset", W'(dst_vld), '0);
    @(negedge src_clk);
    chk(src_rdy == 1'b1, "R1", "src_rdy after reset", W'(src_rdy), 1);
  endtask

  // R6: latency from a write to dst_vld, with edges kept well apart
  task automatic t_latency();
    real ts;
    dst_rdy = 0;
    forever begin
      @(posedge dst_clk); ts = $realtime;
      @(negedge src_clk);
      if ($realtime - ts > 0.5 && $realtime - ts < 2.0) break;
    end
    src_vld = 1; src_flit = 32'hA5A5_0001;
    chk(src_rdy == 1'b1, "R6", "src_rdy before write", W'(src_rdy), 1);
    @(posedge src_clk);
    @(negedge src_clk) src_vld = 0;
    @(posedge dst_clk);
    @(negedge dst_clk);
    chk(dst_vld == 1'b0, "R6", "dst_vld after one dst edge", W'(dst_vld), '0);
    repeat (3) @(posedge dst_clk);
    @(negedge dst_clk);
    chk(dst_vld == 1'b1, "R6", "dst_vld by fourth dst edge", W'(dst_vld), 1);
    chk(dst_flit == 32'hA5A5_0001, "R6", "latency flit", dst_flit, 32'hA5A5_0001);
    dst_rdy = 1;
    @(negedge dst_clk) dst_rdy = 0;
    repeat (4) @(negedge dst_clk);
    chk(dst_vld == 1'b0, "R6", "drained after pop", W'(dst_vld), '0);
  endtask

  // R2: random streaming at a given clock ratio and duty
  task automatic t_stream(input int n, input real dh, input int sp, input int dp);
    int err = 0;
    dst_half = dh;
    exp_q.delete();
    fork
      begin
        int acc = 0;
        while (acc < n) begin
          @(negedge src_clk);
          src_vld = (($urandom % 100) < sp);
          src_flit = $urandom;
          if (src_vld && src_rdy) begin exp_q.push_back(src_flit); acc++; end
        end
        @(negedge src_clk) src_vld = 0;
      end
      begin
        int got = 0;
        while (got < n) begin
          @(negedge dst_clk);
          dst_rdy = (($urandom % 100) < dp);
          if (dst_rdy && dst_vld) begin
            logic [W-1:0] e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 'x;
            if (dst_flit !== e) begin
              err++;
              chk(1'b0, "R2", "stream order", dst_flit, e);
            end
            got++;
          end
        end
        @(negedge dst_clk) dst_rdy = 0;
      end
    join
    chk(err == 0, "R2", "stream miscompares", W'(err), '0);
    repeat (6) @(negedge dst_clk);
    chk(dst_vld == 1'b0, "R2", "no duplicate after stream", W'(dst_vld), '0);
    chk(exp_q.size() == 0, "R2", "no lost flit", W'(exp_q.size()), '0);
  endtask

  // R3, R4, R5, R7: fill, stall, blocked offers, release, drain
  task automatic t_full();
    int acc = 0;
    logic [W-1:0] head;
    dst_half = 5.3;
    dst_rdy = 0;
    exp_q.delete();
    for (int k = 0; k < 2 * D; k++) begin
      @(negedge src_clk);
      if (!src_rdy) break;
      src_vld = 1; src_flit = 32'h1000_0000 + k;
      exp_q.push_back(src_flit); acc++;
    end
    @(negedge src_clk);
    chk(acc == D, "R3", "flits accepted before full", W'(acc), W'(D));
    chk(src_rdy == 1'b0, "R3", "src_rdy when full", W'(src_rdy), '0);
    for (int k = 0; k < 10; k++) begin
      src_vld = 1; src_flit = 32'hDEAD_0000 + k;
      @(negedge src_clk);
      chk(src_rdy == 1'b0, "R5", "offer while full not taken", W'(src_rdy), '0);
    end
    src_vld = 0;
    repeat (4) @(negedge dst_clk);
    head = dst_flit;
    for (int k = 0; k < 5; k++) begin
      @(negedge dst_clk);
      chk(dst_vld == 1'b1 && dst_flit == 32'h1000_0000, "R4", "stalled head held",
          dst_flit, 32'h1000_0000);
    end
    chk(head == 32'h1000_0000, "R4", "head value", head, 32'h1000_0000);
    dst_rdy = 1;
    void'(exp_q.pop_front());
    @(negedge dst_clk) dst_rdy = 0;
    begin
      int w = 0;
      while (!src_rdy && w < 8) begin @(negedge src_clk); w++; end
      chk(src_rdy == 1'b1, "R7", "src_rdy back after pop", W'(w), 8);
    end
    for (int k = 1; k < D; k++) begin
      logic [W-1:0] e;
      @(negedge dst_clk);
      dst_rdy = 1;
      e = exp_q.pop_front();
      chk(dst_vld == 1'b1 && dst_flit == e, "R5", "drain keeps original flits", dst_flit, e);
    end
    @(negedge dst_clk) dst_rdy = 0;
    repeat (6) @(negedge dst_clk);
    chk(dst_vld == 1'b0, "R5", "blocked offers never delivered", W'(dst_vld), '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge src_clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_latency();
    t_stream(200, 5.3, 70, 60);   // receiver slower
    t_stream(200, 1.7, 90, 40);   // receiver much faster
    t_stream(200, 13.1, 95, 95);  // receiver far slower, back-pressure
    t_full();
    t_stream(100, 4.0, 50, 100);  // equal frequency
    finish_run();
  end
endmodule